// File: doc/BRIEF.md
# Exception Entry Unit

This block decides what a processor core must change when it takes an exception. Each request carries a fault kind, a cause code for general exceptions, an access direction, a coprocessor number, the PC of the faulting instruction, a delay-slot flag and the faulting virtual address. The block also reads the current exception-level flag and the three per-segment wide-addressing enables. On the clock edge that accepts a request, it registers one complete commit bundle. The bundle holds the EPC value, the branch-delay bit, a save strobe that tells the status logic to raise the exception level, the cause code, the coprocessor field, the translation-fault captures (faulting address and the page-pair number taken from it) and the new PC vector.

The register storage sits outside the block. Downstream registers latch the bundle during the single cycle in which `commit` is high. All fields are therefore presented together and take effect on one edge.

The control is a two-state machine. `ST_IDLE` means no commit is being presented. `ST_COMMIT` means the bundle is valid for this cycle. The transitions are `accept` (from either state to `ST_COMMIT`, when a request with a legal fault kind is present) and `drain` (from either state to `ST_IDLE`, when no legal request is present). Back-to-back requests keep the machine in `ST_COMMIT` and present one bundle per cycle.

Top module: `exc_entry`

## Requirements
- R1: A request with `req_valid` low, or with `req_fault` equal to 0 (none), 6 or 7, produces no commit: `commit` is low in the following cycle.
- R2: A legal request seen at a rising edge raises `commit` for exactly the following cycle. Legal requests on consecutive edges give consecutive commit cycles. After reset, `commit` is low and the vector output is zero.
- R3: When `exl_in` is low at entry, `commit_save` is 1, `commit_bd` equals `req_in_delay`, and `commit_epc` equals `req_pc`, or `req_pc` minus 4 when `req_in_delay` is 1.
- R4: When `exl_in` is high at entry, `commit_save` is 0, so EPC, the branch-delay bit and the exception level are left untouched downstream.
- R5: Every commit carries `commit_ce` equal to `req_cop`, whatever the value of `exl_in`. For fault kind 1 (general), `commit_code` equals `req_gen_code`.
- R6: Translation fault kinds map to codes as follows. Kind 2 (miss) and kind 3 (invalid entry) give 2 for a load and 3 for a store (`req_store` = 1). Kind 4 (write to a clean page) gives 1. Kind 5 (disallowed address) gives 4 for a load and 5 for a store.
- R7: Fault kinds 1, 4 and 5 give the vector 0xFFFFFFFF_80000180.
- R8: Kinds 2 and 3 give 0xFFFFFFFF_80000180 when `exl_in` is high or the kind is 3. Otherwise the vector is 0xFFFFFFFF_80000080 if the wide-addressing enable of the faulting segment is set, and 0xFFFFFFFF_80000000 if it is not. The segment comes from `req_vaddr[63:62]`: 00 selects `xaddr_en[0]`, 01 selects `xaddr_en[1]`, 11 selects `xaddr_en[2]`, and 10 never counts as wide.
- R9: Kinds 2 to 5 set `commit_tlb_we`, with `commit_badvaddr` equal to `req_vaddr` and `commit_vpn2` equal to `req_vaddr[31:13]`. Kind 1 clears `commit_tlb_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request present |
| req_fault | input | 3 | Fault kind: 0 none, 1 general, 2 miss, 3 invalid, 4 clean-page write, 5 disallowed |
| req_gen_code | input | 5 | Cause code for a general exception |
| req_store | input | 1 | Access direction of a translation fault, 1 = store |
| req_cop | input | CE_W | Coprocessor number for the cause field |
| req_pc | input | PC_W | PC of the faulting instruction |
| req_in_delay | input | 1 | Faulting instruction sits in a branch delay slot |
| req_vaddr | input | VA_W | Faulting virtual address |
| exl_in | input | 1 | Current exception-level flag |
| xaddr_en | input | 3 | Wide-addressing enables: bit0 user, bit1 supervisor, bit2 kernel segment |
| commit | output | 1 | Commit bundle valid this cycle |
| commit_save | output | 1 | Write EPC and branch-delay bit, and raise the exception level |
| commit_epc | output | PC_W | EPC value |
| commit_bd | output | 1 | Branch-delay bit value |
| commit_code | output | 5 | Exception code |
| commit_ce | output | CE_W | Coprocessor field |
| commit_tlb_we | output | 1 | Write the translation-fault captures |
| commit_badvaddr | output | VA_W | Faulting address capture |
| commit_vpn2 | output | VPN2_W | Page-pair number capture |
| commit_vector | output | PC_W | New PC, sign-extended |

## Verification
The bench builds the block with its default parameters: 64-bit PC and address, a 19-bit page-pair field starting at bit 13, and a 4-byte instruction step. With the full 64-bit address, all four segment selectors in the top two address bits can be driven, including the one that never counts as wide. The sign extension of every vector into the upper word is visible, and a page-pair field of all ones checks that no address bits above bit 31 leak into it.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int CODE_W = 5;

    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_GENERAL    = 3'd1,
        FLT_MISS       = 3'd2,
        FLT_INVALID    = 3'd3,
        FLT_MODIFY     = 3'd4,
        FLT_DISALLOWED = 3'd5
    } fault_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } entry_state_e;

    localparam logic [CODE_W-1:0] CODE_MOD  = 5'd1;
    localparam logic [CODE_W-1:0] CODE_TLBL = 5'd2;
    localparam logic [CODE_W-1:0] CODE_TLBS = 5'd3;
    localparam logic [CODE_W-1:0] CODE_ADEL = 5'd4;
    localparam logic [CODE_W-1:0] CODE_ADES = 5'd5;

    localparam logic [31:0] VEC_GENERAL = 32'h8000_0180;
    localparam logic [31:0] VEC_XREFILL = 32'h8000_0080;
    localparam logic [31:0] VEC_REFILL  = 32'h8000_0000;

endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
    import exc_entry_pkg::*;
(
    input  logic [2:0]        fault,
    input  logic              is_store,
    input  logic [CODE_W-1:0] gen_code,
    output logic              legal,
    output logic              is_xlat,
    output logic [CODE_W-1:0] code
);

    always_comb begin
        legal   = 1'b1;
        is_xlat = 1'b1;
        code    = gen_code;
        unique case (fault)
            FLT_GENERAL:    is_xlat = 1'b0;
            FLT_MISS,
            FLT_INVALID:    code = is_store ? CODE_TLBS : CODE_TLBL;
            FLT_MODIFY:     code = CODE_MOD;
            FLT_DISALLOWED: code = is_store ? CODE_ADES : CODE_ADEL;
            default: begin
                legal   = 1'b0;
                is_xlat = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_entry_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic [2:0]      fault,
    input  logic            exl,
    input  logic [1:0]      seg_sel,
    input  logic [2:0]      xaddr_en,
    output logic [PC_W-1:0] vector
);

    localparam int EXT_W = PC_W - 32;

    logic        seg_wide;
    logic [31:0] vec32;

    always_comb begin
        unique case (seg_sel)
            2'b00:   seg_wide = xaddr_en[0];
            2'b01:   seg_wide = xaddr_en[1];
            2'b11:   seg_wide = xaddr_en[2];
            default: seg_wide = 1'b0;
        endcase
    end

    always_comb begin
        vec32 = VEC_GENERAL;
        if (fault == FLT_MISS && !exl) begin
            vec32 = seg_wide ? VEC_XREFILL : VEC_REFILL;
        end
    end

    generate
        if (EXT_W > 0) begin : g_sext
            assign vector = {{EXT_W{vec32[31]}}, vec32};
        end else begin : g_narrow
            assign vector = vec32[PC_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/exc_entry.sv
module exc_entry
    import exc_entry_pkg::*;
#(
    parameter int PC_W       = 64,
    parameter int VA_W       = 64,
    parameter int CE_W       = 2,
    parameter int PAGE_SHIFT = 13,
    parameter int VPN2_W     = 19,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_fault,
    input  logic [CODE_W-1:0] req_gen_code,
    input  logic              req_store,
    input  logic [CE_W-1:0]   req_cop,
    input  logic [PC_W-1:0]   req_pc,
    input  logic              req_in_delay,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              exl_in,
    input  logic [2:0]        xaddr_en,
    output logic              commit,
    output logic              commit_save,
    output logic [PC_W-1:0]   commit_epc,
    output logic              commit_bd,
    output logic [CODE_W-1:0] commit_code,
    output logic [CE_W-1:0]   commit_ce,
    output logic              commit_tlb_we,
    output logic [VA_W-1:0]   commit_badvaddr,
    output logic [VPN2_W-1:0] commit_vpn2,
    output logic [PC_W-1:0]   commit_vector
);

    localparam int VPN2_HI = PAGE_SHIFT + VPN2_W - 1;
    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    entry_state_e        state_q, state_d;
    logic                legal, is_xlat, accept;
    logic [CODE_W-1:0]   code_d;
    logic [PC_W-1:0]     vector_d;
    logic [PC_W-1:0]     epc_d;

    exc_code_map u_code (
        .fault    (req_fault),
        .is_store (req_store),
        .gen_code (req_gen_code),
        .legal    (legal),
        .is_xlat  (is_xlat),
        .code     (code_d)
    );

    exc_vector_sel #(.PC_W(PC_W)) u_vec (
        .fault    (req_fault),
        .exl      (exl_in),
        .seg_sel  (req_vaddr[VA_W-1:VA_W-2]),
        .xaddr_en (xaddr_en),
        .vector   (vector_d)
    );

    assign accept = req_valid && legal;
    assign epc_d  = req_in_delay ? (req_pc - STEP) : req_pc;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = accept ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = accept ? ST_COMMIT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign commit = (state_q == ST_COMMIT);

    // Output bundle register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_save     <= 1'b0;
            commit_epc      <= '0;
            commit_bd       <= 1'b0;
            commit_code     <= '0;
            commit_ce       <= '0;
            commit_tlb_we   <= 1'b0;
            commit_badvaddr <= '0;
            commit_vpn2     <= '0;
            commit_vector   <= '0;
        end else if (accept) begin
            commit_save   <= !exl_in;
            commit_epc    <= epc_d;
            commit_bd     <= req_in_delay;
            commit_code   <= code_d;
            commit_ce     <= req_cop;
            commit_tlb_we <= is_xlat;
            commit_vector <= vector_d;
            if (is_xlat) begin
                commit_badvaddr <= req_vaddr;
                commit_vpn2     <= req_vaddr[VPN2_HI:PAGE_SHIFT];
            end
        end
    end

    // Assertions
    a_r1_no_commit_without_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_fault == 3'd0 || req_fault > 3'd5) |=> !commit);

    a_r2_commit_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fault >= 3'd1 && req_fault <= 3'd5) |=> commit);

    a_r3_epc_from_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && commit_save) |->
            (commit_epc == ($past(req_in_delay) ? $past(req_pc) - STEP : $past(req_pc))));

    a_r4_nested_no_save: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (commit_save == !$past(exl_in)));

    a_r5_ce_follows_cop: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (commit_ce == $past(req_cop)));

    a_r8_nested_general_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !commit_save) |-> (commit_vector[11:0] == 12'h180));

    a_r9_vpn2_from_vaddr: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && commit_tlb_we) |-> (commit_vpn2 == $past(req_vaddr[VPN2_HI:PAGE_SHIFT])));

endmodule

// File: tb/test_exc_entry.sv
module test_exc_entry;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_fault;
    logic [4:0]  req_gen_code;
    logic        req_store;
    logic [1:0]  req_cop;
    logic [63:0] req_pc;
    logic        req_in_delay;
    logic [63:0] req_vaddr;
    logic        exl_in;
    logic [2:0]  xaddr_en;
    logic        commit, commit_save, commit_bd, commit_tlb_we;
    logic [63:0] commit_epc, commit_badvaddr, commit_vector;
    logic [4:0]  commit_code;
    logic [1:0]  commit_ce;
    logic [18:0] commit_vpn2;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [63:0] V180 = 64'hFFFF_FFFF_8000_0180;
    localparam logic [63:0] V080 = 64'hFFFF_FFFF_8000_0080;
    localparam logic [63:0] V000 = 64'hFFFF_FFFF_8000_0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry i_exc_entry (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fault(req_fault),
        .req_gen_code(req_gen_code), .req_store(req_store), .req_cop(req_cop),
        .req_pc(req_pc), .req_in_delay(req_in_delay), .req_vaddr(req_vaddr),
        .exl_in(exl_in), .xaddr_en(xaddr_en), .commit(commit),
        .commit_save(commit_save), .commit_epc(commit_epc), .commit_bd(commit_bd),
        .commit_code(commit_code), .commit_ce(commit_ce),
        .commit_tlb_we(commit_tlb_we), .commit_badvaddr(commit_badvaddr),
        .commit_vpn2(commit_vpn2), .commit_vector(commit_vector)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge; the request is sampled at the next rising edge
    // and the commit bundle is inspected at the falling edge after it.
    task automatic fire(input logic [2:0] flt, input logic [4:0] gcode,
                        input logic st, input logic [1:0] cop,
                        input logic [63:0] pc, input logic dly,
                        input logic [63:0] va, input logic exl,
                        input logic [2:0] xen);
        req_valid = 1'b1; req_fault = flt; req_gen_code = gcode;
        req_store = st; req_cop = cop; req_pc = pc; req_in_delay = dly;
        req_vaddr = va; exl_in = exl; xaddr_en = xen;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2", "commit after reset", {63'd0, commit}, 64'd0);
        chk("R2", "vector after reset", commit_vector, 64'd0);
    endtask

    task automatic t_r1_ignored();
        fire(3'd0, 5'd8, 1'b0, 2'd0, 64'h100, 1'b0, 64'h0, 1'b0, 3'b000);
        chk("R1", "commit for kind 0", {63'd0, commit}, 64'd0);
        fire(3'd6, 5'd8, 1'b0, 2'd0, 64'h100, 1'b0, 64'h0, 1'b0, 3'b000);
        chk("R1", "commit for kind 6", {63'd0, commit}, 64'd0);
        fire(3'd7, 5'd8, 1'b0, 2'd0, 64'h100, 1'b0, 64'h0, 1'b0, 3'b000);
        chk("R1", "commit for kind 7", {63'd0, commit}, 64'd0);
        req_fault = 3'd1;
        @(negedge clk);
        chk("R1", "commit with valid low", {63'd0, commit}, 64'd0);
    endtask

    task automatic t_general_first();
        fire(3'd1, 5'd8, 1'b0, 2'd0, 64'hFFFF_FFFF_8000_1000, 1'b0, 64'h0, 1'b0, 3'b000);
        chk("R2", "commit", {63'd0, commit}, 64'd1);
        chk("R3", "save", {63'd0, commit_save}, 64'd1);
        chk("R3", "epc", commit_epc, 64'hFFFF_FFFF_8000_1000);
        chk("R3", "bd", {63'd0, commit_bd}, 64'd0);
        chk("R5", "code", {59'd0, commit_code}, 64'd8);
        chk("R7", "vector", commit_vector, V180);
        chk("R9", "tlb_we general", {63'd0, commit_tlb_we}, 64'd0);
        @(negedge clk);
        chk("R2", "commit one cycle only", {63'd0, commit}, 64'd0);
    endtask

    task automatic t_general_delay();
        fire(3'd1, 5'd11, 1'b0, 2'd1, 64'hFFFF_FFFF_8000_2004, 1'b1, 64'h0, 1'b0, 3'b000);
        chk("R3", "epc in delay slot", commit_epc, 64'hFFFF_FFFF_8000_2000);
        chk("R3", "bd in delay slot", {63'd0, commit_bd}, 64'd1);
        chk("R5", "ce", {62'd0, commit_ce}, 64'd1);
        chk("R5", "code 11", {59'd0, commit_code}, 64'd11);
    endtask

    task automatic t_general_nested();
        fire(3'd1, 5'd12, 1'b0, 2'd2, 64'h4000, 1'b1, 64'h0, 1'b1, 3'b000);
        chk("R4", "save when nested", {63'd0, commit_save}, 64'd0);
        chk("R5", "code when nested", {59'd0, commit_code}, 64'd12);
        chk("R5", "ce when nested", {62'd0, commit_ce}, 64'd2);
        chk("R7", "vector when nested", commit_vector, V180);
    endtask

    task automatic t_miss_segments();
        fire(3'd2, 5'd0, 1'b0, 2'd0, 64'h10, 1'b0, 64'h0000_0000_0040_6000, 1'b0, 3'b110);
        chk("R6", "miss load code", {59'd0, commit_code}, 64'd2);
        chk("R8", "user seg narrow", commit_vector, V000);
        chk("R9", "tlb_we", {63'd0, commit_tlb_we}, 64'd1);
        chk("R9", "badvaddr", commit_badvaddr, 64'h0000_0000_0040_6000);
        chk("R9", "vpn2", {45'd0, commit_vpn2}, 64'h203);
        fire(3'd2, 5'd0, 1'b1, 2'd0, 64'h10, 1'b0, 64'h0000_0001_2345_E000, 1'b0, 3'b001);
        chk("R6", "miss store code", {59'd0, commit_code}, 64'd3);
        chk("R8", "user seg wide", commit_vector, V080);
        chk("R9", "vpn2 high bits dropped", {45'd0, commit_vpn2}, 64'h11A2F);
        fire(3'd2, 5'd0, 1'b0, 2'd0, 64'h10, 1'b0, 64'h4000_0000_0000_0000, 1'b0, 3'b010);
        chk("R8", "supervisor seg wide", commit_vector, V080);
        fire(3'd2, 5'd0, 1'b0, 2'd0, 64'h10, 1'b0, 64'hC000_0000_FFFF_E000, 1'b0, 3'b100);
        chk("R8", "kernel seg wide", commit_vector, V080);
        chk("R9", "vpn2 all ones", {45'd0, commit_vpn2}, 64'h7FFFF);
        fire(3'd2, 5'd0, 1'b0, 2'd0, 64'h10, 1'b0, 64'hC000_0000_0000_0000, 1'b0, 3'b011);
        chk("R8", "kernel seg narrow", commit_vector, V000);
        fire(3'd2, 5'd0, 1'b0, 2'd0, 64'h10, 1'b0, 64'h8000_0000_0000_0000, 1'b0, 3'b111);
        chk("R8", "seg 10 never wide", commit_vector, V000);
    endtask

    task automatic t_miss_nested_and_invalid();
        fire(3'd2, 5'd0, 1'b0, 2'd0, 64'h10, 1'b0, 64'h0, 1'b1, 3'b111);
        chk("R8", "miss nested vector", commit_vector, V180);
        chk("R4", "miss nested save", {63'd0, commit_save}, 64'd0);
        fire(3'd3, 5'd0, 1'b1, 2'd0, 64'h10, 1'b0, 64'h0, 1'b0, 3'b111);
        chk("R8", "invalid vector", commit_vector, V180);
        chk("R6", "invalid store code", {59'd0, commit_code}, 64'd3);
        chk("R3", "invalid save", {63'd0, commit_save}, 64'd1);
    endtask

    task automatic t_modify_disallowed();
        fire(3'd4, 5'd0, 1'b1, 2'd0, 64'h10, 1'b0, 64'h0000_0000_0000_2000, 1'b0, 3'b111);
        chk("R6", "modify code", {59'd0, commit_code}, 64'd1);
        chk("R7", "modify vector", commit_vector, V180);
        chk("R9", "modify vpn2", {45'd0, commit_vpn2}, 64'h1);
        fire(3'd5, 5'd0, 1'b0, 2'd0, 64'h10, 1'b0, 64'h8000_0000_0000_4000, 1'b0, 3'b111);
        chk("R6", "disallowed load code", {59'd0, commit_code}, 64'd4);
        chk("R7", "disallowed vector", commit_vector, V180);
        chk("R9", "disallowed badvaddr", commit_badvaddr, 64'h8000_0000_0000_4000);
        fire(3'd5, 5'd0, 1'b1, 2'd0, 64'h10, 1'b0, 64'h0, 1'b0, 3'b111);
        chk("R6", "disallowed store code", {59'd0, commit_code}, 64'd5);
    endtask

    task automatic t_back_to_back();
        req_valid = 1'b1; req_fault = 3'd1; req_gen_code = 5'd9; req_cop = 2'd0;
        req_pc = 64'h200; req_in_delay = 1'b0; exl_in = 1'b0;
        @(negedge clk);
        chk("R2", "first of pair", {63'd0, commit}, 64'd1);
        chk("R2", "first code", {59'd0, commit_code}, 64'd9);
        req_gen_code = 5'd13; exl_in = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "second of pair", {63'd0, commit}, 64'd1);
        chk("R2", "second code", {59'd0, commit_code}, 64'd13);
        @(negedge clk);
        chk("R2", "pair drains", {63'd0, commit}, 64'd0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_fault = 3'd0; req_gen_code = 5'd0;
        req_store = 1'b0; req_cop = 2'd0; req_pc = 64'd0; req_in_delay = 1'b0;
        req_vaddr = 64'd0; exl_in = 1'b0; xaddr_en = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_r1_ignored();
        t_general_first();
        t_general_delay();
        t_general_nested();
        t_miss_segments();
        t_miss_nested_and_invalid();
        t_modify_disallowed();
        t_back_to_back();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule